// File: doc/BRIEF.md
# Quasi-Resonant Switching Cycle Sequencer

This block is the digital timing core of a current-mode flyback controller that runs at the boundary between continuous and discontinuous conduction. It receives comparator results that are already digital: a core-reset indication from the auxiliary winding and a current-sense comparator that goes high when the primary current reaches its setpoint. From these it drives a gate-enable output for the power switch and an enable for the offset current source on the sense pin.

A cycle has three phases. The on-phase starts with a leading-edge blanking window in which the sense comparator is not looked at. After that window, the first high sense sample ends the pulse. The off-phase begins with a minimum off-time window. It limits the switching frequency and hides turn-off ringing, so core-reset edges that arrive inside it are dropped. The switch then turns on again on the next core-reset edge, or when a fallback timeout expires. If the sense comparator is still high during the off-time, the current demand is below the skip level, and no turn-on is allowed. When the comparator drops back, a new cycle starts at once.

Every duration is a parameter counted in clock cycles.

Top module: `qr_cycle_seq`

## Requirements
- R1: During reset, the gate is low. After reset is released, with no core-reset edge and the sense input low, the first gate pulse begins MIN_OFF_CYC+TIMEOUT_CYC cycles after release.
- R2: After the minimum off-time window, a rising edge on `demag_det` with `cs_trip` low raises `gate_on` at the third clock edge after the input rises. The delay is two synchroniser flops plus the phase register.
- R3: For the first LEB_CYC cycles of each on-phase, `cs_trip` is ignored. With `cs_trip` held high from the start of the pulse, the gate stays high for exactly LEB_CYC+1 cycles.
- R4: After the blanking window, `cs_trip` sampled high at a clock edge drops the gate at that edge. While `cs_trip` stays low, the gate stays high.
- R5: The gate stays low for at least MIN_OFF_CYC+1 cycles after each fall. Any core-reset edge that reaches the sequencer inside that window is discarded.
- R6: If no core-reset edge arrives and `cs_trip` is low, the gate rises TIMEOUT_CYC cycles after the minimum off-time window ends, which is MIN_OFF_CYC+TIMEOUT_CYC cycles after it fell.
- R7: While `cs_trip` is high in the waiting part of the off-phase (skip condition), neither a core-reset edge nor an expired timeout turns the gate on.
- R8: When `cs_trip` falls while the sequencer is waiting, the gate rises at the next clock edge, even with no core-reset edge.
- R9: `offset_src_on` is high exactly when `enable` is high and `gate_on` is low.
- R10: Deasserting `enable` drops `gate_on` in the same cycle, without waiting for a clock edge, and clears all timers. After `enable` returns, the sequence restarts as after reset, with the first pulse MIN_OFF_CYC+TIMEOUT_CYC cycles later.
- R11: Core-reset turn-on is edge triggered. If `demag_det` is held high, it gives no further turn-ons after the edge that was seen or discarded, and the timeout takes over.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Run enable; low forces the gate off and clears the timers |
| demag_det | input | 1 | Asynchronous core-reset detect (auxiliary winding below threshold) |
| cs_trip | input | 1 | Current-sense comparator: high when the sensed level is above the setpoint |
| gate_on | output | 1 | Gate drive enable |
| offset_src_on | output | 1 | Enable for the sense-pin offset current source |

## Verification
Directed waveforms place core-reset edges on either side of the edge of the minimum off-time window. One pattern has its edge arrive one cycle too early and one exactly in time, which shows whether the window is inclusive and whether a dropped edge stays dropped. A core-reset level held high separates edge-triggered from level-triggered turn-on, and a sense input held high through the off-phase separates skip blanking from timeout restart. A seeded random phase then drives a plant model: sense ramps of varying length, random core-reset toggles, skip episodes and short enable drops. The gate is compared each cycle against a reference sequencer in the bench, written from the requirements.

// File: rtl/qr_seq_pkg.sv
package qr_seq_pkg;

    typedef enum logic [1:0] {
        QS_BLANK = 2'd0,
        QS_WAIT  = 2'd1,
        QS_ON    = 2'd2
    } qr_phase_e;

    typedef struct packed {
        logic enable;
        logic demag_rise;
        logic cs_hi;
        logic cs_was_hi;
    } qr_evt_t;

    function automatic int span_width(input int a, input int b, input int c);
        int m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        if (m < 1) m = 1;
        return $clog2(m + 1);
    endfunction

endpackage

// File: rtl/qr_edge_sync.sv
module qr_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic rise
);
    logic [STAGES:0] sh;

    always_ff @(posedge clk) begin
        if (rst) sh <= '0;
        else     sh <= {sh[STAGES-1:0], din};
    end

    assign rise = sh[STAGES-1] & ~sh[STAGES];

    p_edge_pulse_r11: assert property (@(posedge clk) disable iff (rst)
        rise |=> !rise);
endmodule

// File: rtl/qr_span_timer.sv
module qr_span_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic [CNT_W-1:0] limit,
    output logic [CNT_W-1:0] cnt,
    output logic             at_limit
);
    assign at_limit = (cnt == limit);

    always_ff @(posedge clk) begin
        if (rst || clr)     cnt <= '0;
        else if (!at_limit) cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/qr_cycle_fsm.sv
module qr_cycle_fsm
    import qr_seq_pkg::*;
#(
    parameter int CNT_W       = 8,
    parameter int MIN_OFF_CYC = 20,
    parameter int LEB_CYC     = 4,
    parameter int TIMEOUT_CYC = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  qr_evt_t          evt,
    input  logic             at_limit,
    output qr_phase_e        phase,
    output logic             timer_clr,
    output logic [CNT_W-1:0] limit
);
    localparam logic [CNT_W-1:0] LIM_BLANK = CNT_W'(MIN_OFF_CYC - 1);
    localparam logic [CNT_W-1:0] LIM_WAIT  = CNT_W'(TIMEOUT_CYC - 1);
    localparam logic [CNT_W-1:0] LIM_ON    = CNT_W'(LEB_CYC);

    qr_phase_e nxt;

    always_comb begin
        nxt = phase;
        unique case (phase)
            QS_BLANK: if (at_limit) nxt = QS_WAIT;
            QS_WAIT:  if (!evt.cs_hi && (evt.demag_rise || at_limit || evt.cs_was_hi))
                          nxt = QS_ON;
            QS_ON:    if (at_limit && evt.cs_hi) nxt = QS_BLANK;
            default:  nxt = QS_BLANK;
        endcase
        if (!evt.enable) nxt = QS_BLANK;
    end

    always_comb begin
        timer_clr = (nxt != phase) || !evt.enable;
        unique case (phase)
            QS_WAIT: limit = LIM_WAIT;
            QS_ON:   limit = LIM_ON;
            default: limit = LIM_BLANK;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) phase <= QS_BLANK;
        else     phase <= nxt;
    end

    // cycle counters used only by the properties below
    logic [31:0] off_len, on_len;
    always_ff @(posedge clk) begin
        if (rst) begin
            off_len <= '0;
            on_len  <= '0;
        end else begin
            off_len <= (phase == QS_ON) ? 32'd0 : off_len + 32'd1;
            on_len  <= (phase == QS_ON) ? on_len + 32'd1 : 32'd0;
        end
    end

    p_min_off_r5: assert property (@(posedge clk) disable iff (rst)
        $rose(phase == QS_ON) |-> off_len > MIN_OFF_CYC);
    p_leb_r3: assert property (@(posedge clk) disable iff (rst)
        ($fell(phase == QS_ON) && $past(evt.enable)) |-> on_len > LEB_CYC);
    p_skip_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (phase == QS_WAIT && evt.cs_hi) |=> phase != QS_ON);
    p_force_off_r10: assert property (@(posedge clk) disable iff (rst)
        !evt.enable |=> phase == QS_BLANK);
endmodule

// File: rtl/qr_cycle_seq.sv
module qr_cycle_seq
    import qr_seq_pkg::*;
#(
    parameter int MIN_OFF_CYC = 1600,
    parameter int LEB_CYC     = 68,
    parameter int TIMEOUT_CYC = 1000,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic enable,
    input  logic demag_det,
    input  logic cs_trip,
    output logic gate_on,
    output logic offset_src_on
);
    localparam int CNT_W = span_width(MIN_OFF_CYC, LEB_CYC, TIMEOUT_CYC);

    logic             demag_rise;
    logic             cs_prev;
    qr_evt_t          evt;
    qr_phase_e        phase;
    logic             timer_clr;
    logic             at_limit;
    logic [CNT_W-1:0] limit;
    logic [CNT_W-1:0] cnt;

    qr_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .din (demag_det),
        .rise(demag_rise)
    );

    always_ff @(posedge clk) begin
        if (rst) cs_prev <= 1'b0;
        else     cs_prev <= cs_trip;
    end

    always_comb begin
        evt.enable     = enable;
        evt.demag_rise = demag_rise;
        evt.cs_hi      = cs_trip;
        evt.cs_was_hi  = cs_prev;
    end

    qr_cycle_fsm #(
        .CNT_W      (CNT_W),
        .MIN_OFF_CYC(MIN_OFF_CYC),
        .LEB_CYC    (LEB_CYC),
        .TIMEOUT_CYC(TIMEOUT_CYC)
    ) u_fsm (
        .clk      (clk),
        .rst      (rst),
        .evt      (evt),
        .at_limit (at_limit),
        .phase    (phase),
        .timer_clr(timer_clr),
        .limit    (limit)
    );

    qr_span_timer #(.CNT_W(CNT_W)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .clr     (timer_clr),
        .limit   (limit),
        .cnt     (cnt),
        .at_limit(at_limit)
    );

    assign gate_on       = (phase == QS_ON) && enable;
    assign offset_src_on = enable && !gate_on;

    p_timer_clear_r10: assert property (@(posedge clk) disable iff (rst)
        !enable |=> cnt == '0);
    p_timeout_r6: assert property (@(posedge clk) disable iff (rst)
        (phase == QS_WAIT && at_limit && !cs_trip && enable) |=> phase == QS_ON);
endmodule

// File: tb/qr_cycle_seq_bench.sv
`timescale 1ns/1ps
module qr_cycle_seq_bench;
    localparam int MO = 20;
    localparam int LB = 4;
    localparam int TO = 12;

    logic clk = 1'b0;
    logic rst = 1'b1, en = 1'b1, demag = 1'b0, cs = 1'b0;
    logic gate, src;
    int   checks = 0, fails = 0;
    bit   done = 1'b0;

    always #2.5 clk = ~clk;

    qr_cycle_seq #(.MIN_OFF_CYC(MO), .LEB_CYC(LB), .TIMEOUT_CYC(TO)) u_qr_cycle_seq (
        .clk(clk), .rst(rst), .enable(en), .demag_det(demag), .cs_trip(cs),
        .gate_on(gate), .offset_src_on(src)
    );

    // reference sequencer written from the requirements: 0 blank, 1 wait, 2 on
    int   ms = 0, mc = 0;
    logic m1 = 0, m2 = 0, m3 = 0, mcs = 0;
    always @(posedge clk) begin
        logic edge_seen;
        edge_seen = m2 & ~m3;
        if (rst || !en) begin
            ms = 0; mc = 0;
        end else if (ms == 0) begin
            if (mc == MO - 1) begin ms = 1; mc = 0; end else mc++;
        end else if (ms == 1) begin
            if (!cs && (edge_seen || mc == TO - 1 || mcs)) begin ms = 2; mc = 0; end
            else if (mc != TO - 1) mc++;
        end else begin
            if (mc == LB && cs) begin ms = 0; mc = 0; end
            else if (mc != LB) mc++;
        end
        if (rst) begin mcs = 0; m1 = 0; m2 = 0; m3 = 0; end
        else begin mcs = cs; m3 = m2; m2 = m1; m1 = demag; end
    end

    function automatic bit ref_gate(int st, logic e);
        return (st == 2) && e;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wait_level(input logic lvl, input int lim, output int k);
        k = -1;
        for (int i = 1; i <= lim; i++) begin
            @(negedge clk);
            if (gate == lvl) begin k = i; break; end
        end
    endtask

    task automatic skip_cycles(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        int k, hi, on_cyc, ramp;
        logic skipf;
        skip_cycles(4);
        chk(gate == 1'b0, "R1 gate in reset", gate, 0);
        chk(src == 1'b1, "R9 source in reset", src, 1);
        rst = 1'b0;
        wait_level(1'b1, 100, k);
        chk(k == MO + TO, "R1 first pulse delay", k, MO + TO);
        chk(src == 1'b0, "R9 source while gate high", src, 0);
        // R3: sense high from start of pulse
        cs = 1'b1;
        wait_level(1'b0, 50, k);
        chk(k == LB + 1, "R3 blanked on-time", k, LB + 1);
        chk(src == 1'b1, "R9 source while gate low", src, 1);
        cs = 1'b0;
        // R5/R11: edge inside blank, level held, timeout takes over
        skip_cycles(5); demag = 1'b1;
        wait_level(1'b1, 100, k);
        chk(k == MO + TO - 5, "R11 held level no retrigger", k, MO + TO - 5);
        demag = 1'b0;
        skip_cycles(10);
        chk(gate == 1'b1, "R4 gate holds while sense low", gate, 1);
        cs = 1'b1; wait_level(1'b0, 10, k);
        chk(k == 1, "R4 turn-off after blanking", k, 1);
        cs = 1'b0;
        // R5 boundary: edge one cycle too early
        skip_cycles(17); demag = 1'b1;
        wait_level(1'b1, 100, k);
        chk(k == MO + TO - 17, "R5 edge at window end discarded", k, MO + TO - 17);
        demag = 1'b0;
        cs = 1'b1; wait_level(1'b0, 50, k); cs = 1'b0;
        // R2: edge just in time
        skip_cycles(18); demag = 1'b1;
        wait_level(1'b1, 100, k);
        chk(k == 3, "R2 edge to gate latency", k, 3);
        demag = 1'b0;
        // R7: skip hold
        cs = 1'b1; wait_level(1'b0, 50, k);
        skip_cycles(25); demag = 1'b1; skip_cycles(3); demag = 1'b0;
        hi = 0;
        for (int i = 0; i < 60; i++) begin @(negedge clk); if (gate) hi++; end
        chk(hi == 0, "R7 no pulse during skip", hi, 0);
        cs = 1'b0;
        wait_level(1'b1, 10, k);
        chk(k == 1, "R8 restart on sense release", k, 1);
        // R10: enable drop
        en = 1'b0; #1;
        chk(gate == 1'b0, "R10 immediate gate off", gate, 0);
        chk(src == 1'b0, "R9 source off when disabled", src, 0);
        skip_cycles(5);
        chk(gate == 1'b0, "R10 gate stays off", gate, 0);
        en = 1'b1;
        wait_level(1'b1, 100, k);
        chk(k == MO + TO, "R10 timers cleared", k, MO + TO);
        // random phase against the reference sequencer
        void'($urandom(32'd4711));
        on_cyc = 0; ramp = 3; skipf = 1'b0;
        for (int i = 0; i < 6000; i++) begin
            @(negedge clk);
            chk(gate == ref_gate(ms, en), "R2-model gate", gate, ref_gate(ms, en));
            chk(src == (en && !gate), "R9 source", src, en && !gate);
            if (gate) on_cyc++;
            else begin on_cyc = 0; ramp = $urandom_range(0, 8); end
            if ($urandom_range(0, 39) == 0) skipf = ~skipf;
            cs = gate ? (on_cyc > ramp) : skipf;
            if ($urandom_range(0, 7) == 0) demag = ~demag;
            if (!en) begin if ($urandom_range(0, 3) == 0) en = 1'b1; end
            else if ($urandom_range(0, 299) == 0) en = 1'b0;
        end
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule